// File: doc/BRIEF.md
# Tag-Matching Operand Wait Stations

This block is a small pool of waiting stations that sits in front of one floating-point execution unit in an out-of-order core. At issue it takes an operation code and two source operands. Each operand comes with a 4-bit producer tag. A tag of zero means the accompanying value is already valid. Any other tag names the unit that will later produce the value.

Every station watches the shared result bus. When the broadcast tag equals a tag that a station is waiting on, the station takes the broadcast value and marks that operand as present. This happens in every station and in both operand fields at once. A station whose two operands are both present may be dispatched to the execution unit. Dispatch always chooses the lowest-numbered such station. A dispatched station becomes free again.

Each station owns a fixed global tag, `BASE_TAG + index` (10, 11 and 12 by default). The tag of the station being dispatched is presented alongside its operands, so that the execution unit can broadcast its result under that name.

Top module: `rs_array`

## Requirements
- R1: After reset, `busy_vec` is all zero, `iss_full` is 0 and `disp_valid` is 0.
- R2: An issued operand whose tag is 0 is stored with the given value. A station with both tags 0 raises `disp_valid` after the issue edge and presents the issued `iss_op` and values.
- R3: An issued operand with a non-zero tag is held as waiting, and the station is not ready until that tag is broadcast.
- R4: A broadcast (`cdb_valid`=1) fills every waiting operand field, in any busy station, whose tag equals `cdb_tag`. The field takes `cdb_data` and clears its tag to 0 at that edge. A ready station stays ready until it is dispatched.
- R5: A broadcast in the same cycle as an issue whose incoming tag equals `cdb_tag` is captured into the new station. The wakeup is not lost.
- R6: A broadcast whose tag matches no waiting field leaves every station unchanged.
- R7: `disp_valid` is high when any station is ready. The selected station is the lowest-index ready one, and `disp_tag` equals `BASE_TAG` plus that index.
- R8: The selected station is freed at an edge where `disp_valid` and `disp_ready` are both 1. With `disp_ready`=0 it stays busy and stays selected.
- R9: `iss_full` is 1 exactly when every station is busy. An issue while full is ignored and changes no station.
- R10: An accepted issue fills the lowest-index free station, and sets its bit in `busy_vec` (bit i is station i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code to hold |
| iss_tag_a | input | 4 | Producer tag of operand A (0 = value valid) |
| iss_data_a | input | DATA_W | Value of operand A |
| iss_tag_b | input | 4 | Producer tag of operand B (0 = value valid) |
| iss_data_b | input | DATA_W | Value of operand B |
| iss_full | output | 1 | No free station; issue is not accepted |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 4 | Tag of the broadcasting producer |
| cdb_data | input | DATA_W | Broadcast value |
| disp_ready | input | 1 | Execution unit accepts the dispatch |
| disp_valid | output | 1 | A station is ready to dispatch |
| disp_op | output | OP_W | Operation of the selected station |
| disp_tag | output | 4 | Global tag of the selected station |
| disp_data_a | output | DATA_W | Operand A value of the selected station |
| disp_data_b | output | DATA_W | Operand B value of the selected station |
| busy_vec | output | N_ENT | Occupancy, one bit per station |

## Verification
Issue, broadcast capture and release all act at one clock edge and are seen on the outputs right after that edge. `busy_vec` and `iss_full` change one edge after an accepted issue or a dispatch handshake. `disp_valid` and the dispatch fields follow one edge after the last missing operand arrives, or after the issue of a fully valid operation. The bench drives every input at the falling edge and reads the outputs at the next falling edge. Each expectation therefore sits exactly one rising edge after the stimulus that causes it, and a same-cycle broadcast is driven together with the issue it must wake.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int TAG_W = 4;
  typedef logic [TAG_W-1:0] tag_t;
  localparam tag_t TAG_HAVE = '0;

  // broadcast matches a field that is still waiting
  function automatic logic tag_hit(tag_t waiting, logic bus_v, tag_t bus_tag);
    return bus_v && (waiting != TAG_HAVE) && (waiting == bus_tag);
  endfunction

  function automatic tag_t station_tag(int base, int idx);
    return tag_t'(base + idx);
  endfunction
endpackage

// File: rtl/rs_operand.sv
module rs_operand
  import rs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  logic              load,
  input  tag_t              in_tag,
  input  logic [DATA_W-1:0] in_data,
  input  logic              bus_v,
  input  tag_t              bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              present,
  output logic [DATA_W-1:0] data_q
);
  tag_t tag_q;
  logic hit_in;
  logic hit_hold;

  assign hit_in   = load && tag_hit(in_tag, bus_v, bus_tag);
  assign hit_hold = live && !load && tag_hit(tag_q, bus_v, bus_tag);
  assign present  = (tag_q == TAG_HAVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q  <= TAG_HAVE;
      data_q <= '0;
    end else if (load) begin
      if (hit_in) begin
        tag_q  <= TAG_HAVE;
        data_q <= bus_data;
      end else begin
        tag_q  <= in_tag;
        data_q <= in_data;
      end
    end else if (hit_hold) begin
      tag_q  <= TAG_HAVE;
      data_q <= bus_data;
    end
  end
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              release_en,
  input  logic [OP_W-1:0]   op_in,
  input  tag_t              tag_a,
  input  logic [DATA_W-1:0] data_a,
  input  tag_t              tag_b,
  input  logic [DATA_W-1:0] data_b,
  input  logic              bus_v,
  input  tag_t              bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              busy_q,
  output logic              ready,
  output logic [OP_W-1:0]   op_q,
  output logic [DATA_W-1:0] a_q,
  output logic [DATA_W-1:0] b_q
);
  logic a_have;
  logic b_have;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= '0;
    end else if (alloc) begin
      busy_q <= 1'b1;
      op_q   <= op_in;
    end else if (release_en) begin
      busy_q <= 1'b0;
    end
  end

  rs_operand #(.DATA_W(DATA_W)) u_opa (
    .clk(clk), .rst_n(rst_n), .live(busy_q), .load(alloc),
    .in_tag(tag_a), .in_data(data_a),
    .bus_v(bus_v), .bus_tag(bus_tag), .bus_data(bus_data),
    .present(a_have), .data_q(a_q)
  );

  rs_operand #(.DATA_W(DATA_W)) u_opb (
    .clk(clk), .rst_n(rst_n), .live(busy_q), .load(alloc),
    .in_tag(tag_b), .in_data(data_b),
    .bus_v(bus_v), .bus_tag(bus_tag), .bus_data(bus_data),
    .present(b_have), .data_q(b_q)
  );

  assign ready = busy_q && a_have && b_have;
endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = N'(1) << i;
    end
  end
  assign any = |req;
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_pkg::*;
#(
  parameter int N_ENT    = 3,
  parameter int DATA_W   = 32,
  parameter int OP_W     = 4,
  parameter int BASE_TAG = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [3:0]        iss_tag_a,
  input  logic [DATA_W-1:0] iss_data_a,
  input  logic [3:0]        iss_tag_b,
  input  logic [DATA_W-1:0] iss_data_b,
  output logic              iss_full,
  input  logic              cdb_valid,
  input  logic [3:0]        cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              disp_ready,
  output logic              disp_valid,
  output logic [OP_W-1:0]   disp_op,
  output logic [3:0]        disp_tag,
  output logic [DATA_W-1:0] disp_data_a,
  output logic [DATA_W-1:0] disp_data_b,
  output logic [N_ENT-1:0]  busy_vec
);
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [N_ENT-1:0]  ready_vec;
  logic [N_ENT-1:0]  alloc_oh;
  logic [N_ENT-1:0]  disp_oh;
  logic              alloc_any;
  logic              iss_fire;
  logic              disp_fire;
  logic [IDX_W-1:0]  disp_idx;
  logic [OP_W-1:0]   op_arr [N_ENT];
  logic [DATA_W-1:0] a_arr  [N_ENT];
  logic [DATA_W-1:0] b_arr  [N_ENT];

  rs_pick #(.N(N_ENT)) u_free_pick (
    .req(~busy_vec), .any(alloc_any), .gnt(alloc_oh)
  );
  rs_pick #(.N(N_ENT)) u_disp_pick (
    .req(ready_vec), .any(disp_valid), .gnt(disp_oh)
  );

  assign iss_full  = !alloc_any;
  assign iss_fire  = iss_valid && alloc_any;
  assign disp_fire = disp_valid && disp_ready;

  for (genvar g = 0; g < N_ENT; g++) begin : g_st
    rs_station #(.DATA_W(DATA_W), .OP_W(OP_W)) u_st (
      .clk(clk), .rst_n(rst_n),
      .alloc(iss_fire && alloc_oh[g]),
      .release_en(disp_fire && disp_oh[g]),
      .op_in(iss_op),
      .tag_a(tag_t'(iss_tag_a)), .data_a(iss_data_a),
      .tag_b(tag_t'(iss_tag_b)), .data_b(iss_data_b),
      .bus_v(cdb_valid), .bus_tag(tag_t'(cdb_tag)), .bus_data(cdb_data),
      .busy_q(busy_vec[g]), .ready(ready_vec[g]),
      .op_q(op_arr[g]), .a_q(a_arr[g]), .b_q(b_arr[g])
    );
  end

  always_comb begin
    disp_idx    = '0;
    disp_op     = '0;
    disp_data_a = '0;
    disp_data_b = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (disp_oh[i]) begin
        disp_idx    = IDX_W'(i);
        disp_op     = op_arr[i];
        disp_data_a = a_arr[i];
        disp_data_b = b_arr[i];
      end
    end
  end

  assign disp_tag = station_tag(BASE_TAG, int'(disp_idx));
endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
  parameter int N_ENT = 3,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             iss_full,
  input logic             iss_fire,
  input logic             disp_valid,
  input logic             disp_fire,
  input logic [IDX_W-1:0] disp_idx,
  input logic [N_ENT-1:0] busy_vec,
  input logic [N_ENT-1:0] ready_vec,
  input logic [N_ENT-1:0] alloc_oh,
  input logic [N_ENT-1:0] disp_oh
);
  logic [N_ENT-1:0] below_mask;
  assign below_mask = (N_ENT'(1) << disp_idx) - N_ENT'(1);

  // R9
  full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_full && !disp_fire) |=> (busy_vec == $past(busy_vec)));

  // R7
  disp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ($countones(disp_oh) == 1 && ready_vec[disp_idx]));

  // R7
  disp_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ((ready_vec & below_mask) == '0));

  // R8
  release_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> !busy_vec[$past(disp_idx)]);

  for (genvar g = 0; g < N_ENT; g++) begin : g_chk
    // R4
    ready_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_vec[g] && !(disp_fire && disp_oh[g])) |=> ready_vec[g]);
    // R10
    free_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_vec[g] && !(iss_fire && alloc_oh[g])) |=> !busy_vec[g]);
  end
endmodule

bind rs_array rs_array_chk #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_full(iss_full),
  .iss_fire(iss_fire), .disp_valid(disp_valid), .disp_fire(disp_fire),
  .disp_idx(disp_idx), .busy_vec(busy_vec), .ready_vec(ready_vec),
  .alloc_oh(alloc_oh), .disp_oh(disp_oh)
);

// File: tb/tb_rs_array.sv
module tb_rs_array;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic iss_valid, iss_full, cdb_valid, disp_ready, disp_valid;
  logic [3:0] iss_op, disp_op;
  logic [3:0] iss_tag_a, iss_tag_b, cdb_tag, disp_tag;
  logic [DW-1:0] iss_data_a, iss_data_b, cdb_data, disp_data_a, disp_data_b;
  logic [2:0] busy_vec;
  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  rs_array #(.N_ENT(3), .DATA_W(DW), .OP_W(4), .BASE_TAG(10)) dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_tag_a(iss_tag_a), .iss_data_a(iss_data_a),
    .iss_tag_b(iss_tag_b), .iss_data_b(iss_data_b), .iss_full(iss_full),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .disp_ready(disp_ready), .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_tag(disp_tag), .disp_data_a(disp_data_a), .disp_data_b(disp_data_b),
    .busy_vec(busy_vec)
  );

  typedef struct packed {
    logic [3:0] ta; logic [15:0] va;
    logic [3:0] tb; logic [15:0] vb;
    logic [3:0] c1t; logic [15:0] c1v;
    logic [3:0] c2t; logic [15:0] c2v;
    logic erdy; logic [15:0] ea; logic [15:0] eb;
  } vec_t;

  // c1 = broadcast with the issue, c2 = broadcast one cycle later, tag 0 = none
  localparam vec_t VECS [6] = '{
    '{4'd0, 16'h0011, 4'd0, 16'h0022, 4'd0,  16'h0000, 4'd0, 16'h0000, 1'b1, 16'h0011, 16'h0022},
    '{4'd3, 16'hdead, 4'd0, 16'h0044, 4'd0,  16'h0000, 4'd3, 16'h0055, 1'b1, 16'h0055, 16'h0044},
    '{4'd8, 16'h0000, 4'd9, 16'h0000, 4'd8,  16'h0066, 4'd9, 16'h0077, 1'b1, 16'h0066, 16'h0077},
    '{4'd5, 16'h0000, 4'd0, 16'h0012, 4'd0,  16'h0000, 4'd6, 16'h0099, 1'b0, 16'h0000, 16'h0000},
    '{4'd0, 16'h0001, 4'd12, 16'h0000, 4'd12, 16'h00aa, 4'd0, 16'h0000, 1'b1, 16'h0001, 16'h00aa},
    '{4'd2, 16'h0000, 4'd2, 16'h0000, 4'd0,  16'h0000, 4'd2, 16'h00bb, 1'b1, 16'h00bb, 16'h00bb}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    iss_valid = 0; iss_op = 0; iss_tag_a = 0; iss_data_a = 0;
    iss_tag_b = 0; iss_data_b = 0; cdb_valid = 0; cdb_tag = 0;
    cdb_data = 0; disp_ready = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    tick();
    tick();
    rst_n = 1;
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] ta, input logic [DW-1:0] va,
                       input logic [3:0] tb, input logic [DW-1:0] vb);
    iss_valid = 1; iss_op = op; iss_tag_a = ta; iss_data_a = va;
    iss_tag_b = tb; iss_data_b = vb;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [DW-1:0] v);
    cdb_valid = (t != 0); cdb_tag = t; cdb_data = v;
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    do_reset();
    // R1 reset state
    chk("R1 busy", 32'(busy_vec), 0);
    chk("R1 full", 32'(iss_full), 0);
    chk("R1 disp_valid", 32'(disp_valid), 0);

    // Table: R2 R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      vec_t v = VECS[i];
      do_reset();
      issue(4'(i), v.ta, v.va, v.tb, v.vb);
      bcast(v.c1t, v.c1v);
      tick();
      iss_valid = 0;
      bcast(v.c2t, v.c2v);
      tick();
      bcast(0, 0);
      chk($sformatf("R3/R4/R5/R6 vec%0d ready", i), 32'(disp_valid), 32'(v.erdy));
      if (v.erdy) begin
        chk($sformatf("R2/R4 vec%0d a", i), 32'(disp_data_a), 32'(v.ea));
        chk($sformatf("R2/R4 vec%0d b", i), 32'(disp_data_b), 32'(v.eb));
        chk($sformatf("R2 vec%0d op", i), 32'(disp_op), i);
      end
    end

    // Directed: fill, full, broadcast to all, dispatch order
    do_reset();
    for (int k = 0; k < 3; k++) begin
      issue(4'd7, 4'd4, 16'h0, 4'd0, 16'(16'h100 + k));
      tick();
    end
    iss_valid = 0;
    chk("R9 full", 32'(iss_full), 1);
    chk("R10 busy", 32'(busy_vec), 3'b111);
    chk("R3 waiting", 32'(disp_valid), 0);
    issue(4'd1, 4'd0, 16'h0f0f, 4'd0, 16'h0f0f);
    tick();
    iss_valid = 0;
    chk("R9 ignored issue", 32'(disp_valid), 0);
    chk("R9 busy kept", 32'(busy_vec), 3'b111);
    bcast(4'd4, 16'h0444);
    tick();
    bcast(0, 0);
    chk("R4 all woke tag", 32'(disp_tag), 10);
    chk("R4 all woke a", 32'(disp_data_a), 16'h0444);
    chk("R7 lowest b", 32'(disp_data_b), 16'h0100);
    disp_ready = 1;
    tick();
    disp_ready = 0;
    chk("R8 freed", 32'(busy_vec), 3'b110);
    chk("R7 next tag", 32'(disp_tag), 11);
    chk("R4 entry1 a", 32'(disp_data_a), 16'h0444);
    chk("R9 not full", 32'(iss_full), 0);
    tick();
    chk("R8 hold tag", 32'(disp_tag), 11);
    chk("R8 hold busy", 32'(busy_vec), 3'b110);
    issue(4'd3, 4'd0, 16'h005a, 4'd0, 16'h005b);
    tick();
    iss_valid = 0;
    chk("R10 refill busy", 32'(busy_vec), 3'b111);
    chk("R10 refill tag", 32'(disp_tag), 10);
    chk("R10 refill a", 32'(disp_data_a), 16'h005a);
    chk("R2 refill op", 32'(disp_op), 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule